// File: doc/BRIEF.md
# Conditional Skip Evaluator

This unit decides, for a processor's test-and-branch style instructions, whether the instruction that follows must be bypassed. The sequencer presents a test strobe along with a 4-bit test code and the operands: accumulator, memory operand, immediate, the B pointer, the carry flag and a bit index. One clock later the unit returns a result strobe and a skip request. It is the only place in the core where these conditions are evaluated.

Most tests follow an "execute the next instruction only if the condition holds" rule, so a skip is requested when the condition is false. The two zero tests work the other way round and skip when their result is zero. The decrement test also produces a write-back of the decremented operand, which is presented alongside the result strobe. Decoding instruction lengths and advancing the program counter are handled elsewhere.

Top module: `skip_eval`

## Requirements
- R1: While rstN is low, and in the first cycle after it is released, skipValid, skipReq and regWrEn are all 0.
- R2: Code 1 compares the accumulator with the memory operand. skipReq is 1 when they differ.
- R3: Code 2 compares the memory operand with the immediate. skipReq is 1 when they differ.
- R4: Code 3 is a not-equal test on the accumulator and the memory operand. skipReq is 1 when they are equal.
- R5: Code 4 is an unsigned greater-than test. skipReq is 1 unless the accumulator is strictly greater than the memory operand, so equal operands cause a skip.
- R6: Code 5 compares B pointer bits [3:0] with immediate bits [3:0]. skipReq is 1 when these nibbles are equal. The upper bits of both operands have no effect.
- R7: Code 6 takes the bitwise AND of the accumulator and the immediate. skipReq is 1 when the AND is zero. No write-back is produced (regWrEn stays 0).
- R8: Code 7 sets regWrEn to 1 and regWrData to (memory operand − 1) modulo 256. skipReq is 1 exactly when that new value is zero. An operand of 0 wraps to 0xFF without a skip, and an operand of 1 gives 0x00 with a skip.
- R9: Code 8 tests bit bitIdx (0 to 7) of the memory operand. skipReq is 1 when that bit is 0.
- R10: Code 9 requests a skip when carryIn is 0. Code 10 requests a skip when carryIn is 1.
- R11: Results appear on the clock edge after the edge that samples testValid. Each accepted strobe produces a skipValid pulse lasting exactly one cycle. skipReq and regWrEn are only ever 1 together with skipValid.
- R12: When testValid is 0, or when the code is 0 or in the range 11 to 15, the next cycle has skipValid, skipReq and regWrEn all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| testValid | input | 1 | A test instruction is presented this cycle |
| testSel | input | 4 | Test code (see requirements) |
| accIn | input | DATA_W | Accumulator value |
| memIn | input | DATA_W | Memory operand / counter register |
| immIn | input | DATA_W | Immediate operand |
| bPtrIn | input | DATA_W | B pointer |
| carryIn | input | 1 | Carry flag |
| bitIdx | input | IDX_W | Bit index for the bit test |
| skipValid | output | 1 | Result strobe, one cycle |
| skipReq | output | 1 | Skip the next instruction |
| regWrEn | output | 1 | Write-back of the decremented counter |
| regWrData | output | DATA_W | Decremented counter value |

## Verification
All internal state in this block is a single pipeline stage, so any fault shows up at the ports on the cycle right after the offending strobe. A wrong decoded strobe would produce a skipReq or regWrEn of the wrong polarity, or assert them on an idle code, and the per-clock comparison against the behavioural model would flag that cycle. A stale or mis-gated write-back register would show a wrong regWrData the next time a decrement is issued. The random sweeps are combined with directed cases for the wrap from 0 to 0xFF, equal operands in the greater-than test, and B pointers whose upper bits differ while the low nibbles match.

// File: rtl/skip_eval_pkg.sv
package skip_eval_pkg;

  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] TST_EQ_MEM = 4'd1;
  localparam logic [SEL_W-1:0] TST_EQ_IMM = 4'd2;
  localparam logic [SEL_W-1:0] TST_NE     = 4'd3;
  localparam logic [SEL_W-1:0] TST_GT     = 4'd4;
  localparam logic [SEL_W-1:0] TST_NIB    = 4'd5;
  localparam logic [SEL_W-1:0] TST_ANDZ   = 4'd6;
  localparam logic [SEL_W-1:0] TST_DECZ   = 4'd7;
  localparam logic [SEL_W-1:0] TST_BIT    = 4'd8;
  localparam logic [SEL_W-1:0] TST_CSET   = 4'd9;
  localparam logic [SEL_W-1:0] TST_CCLR   = 4'd10;

  // One-hot strobes from control to datapath; fire marks any accepted test.
  typedef struct packed {
    logic fire;
    logic cmpEqMem;
    logic cmpEqImm;
    logic cmpNe;
    logic cmpGt;
    logic cmpNib;
    logic andZero;
    logic decZero;
    logic bitTest;
    logic carrySet;
    logic carryClr;
  } strobes_t;

endpackage

// File: rtl/skip_eval_ctrl.sv
module skip_eval_ctrl
  import skip_eval_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             testValid,
  input  logic [SEL_W-1:0] testSel,
  output strobes_t         stb,
  output logic             skipValid,
  output logic             regWrEn
);

  strobes_t decoded;

  always_comb begin
    decoded = '0;
    unique case (testSel)
      TST_EQ_MEM: decoded.cmpEqMem = 1'b1;
      TST_EQ_IMM: decoded.cmpEqImm = 1'b1;
      TST_NE:     decoded.cmpNe    = 1'b1;
      TST_GT:     decoded.cmpGt    = 1'b1;
      TST_NIB:    decoded.cmpNib   = 1'b1;
      TST_ANDZ:   decoded.andZero  = 1'b1;
      TST_DECZ:   decoded.decZero  = 1'b1;
      TST_BIT:    decoded.bitTest  = 1'b1;
      TST_CSET:   decoded.carrySet = 1'b1;
      TST_CCLR:   decoded.carryClr = 1'b1;
      default:    decoded = '0;
    endcase
    decoded.fire = |decoded[$bits(strobes_t)-2:0];
    stb = testValid ? decoded : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skipValid <= 1'b0;
      regWrEn   <= 1'b0;
    end else begin
      skipValid <= stb.fire;
      regWrEn   <= stb.decZero;
    end
  end

endmodule

// File: rtl/skip_eval_dp.sv
module skip_eval_dp
  import skip_eval_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] memIn,
  input  logic [DATA_W-1:0] immIn,
  input  logic [DATA_W-1:0] bPtrIn,
  input  logic              carryIn,
  input  logic [IDX_W-1:0]  bitIdx,
  output logic              skipReq,
  output logic [DATA_W-1:0] regWrData
);

  localparam int NIB_W = 4;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] decVal;
  logic [DATA_W-1:0] bitHit;
  logic              bitOne;
  logic              skipNow;

  assign decVal = memIn - ONE;

  genvar g;
  generate
    for (g = 0; g < DATA_W; g++) begin : gBitSel
      assign bitHit[g] = (bitIdx == IDX_W'(g)) & memIn[g];
    end
  endgenerate
  assign bitOne = |bitHit;

  // Skip means "condition for executing the next instruction is false",
  // except the two zero tests, which skip on a zero result.
  always_comb begin
    skipNow = 1'b0;
    if (stb.cmpEqMem) skipNow = (accIn != memIn);
    if (stb.cmpEqImm) skipNow = (memIn != immIn);
    if (stb.cmpNe)    skipNow = (accIn == memIn);
    if (stb.cmpGt)    skipNow = !(accIn > memIn);
    if (stb.cmpNib)   skipNow = (bPtrIn[NIB_W-1:0] == immIn[NIB_W-1:0]);
    if (stb.andZero)  skipNow = ((accIn & immIn) == '0);
    if (stb.decZero)  skipNow = (decVal == '0);
    if (stb.bitTest)  skipNow = !bitOne;
    if (stb.carrySet) skipNow = !carryIn;
    if (stb.carryClr) skipNow = carryIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skipReq   <= 1'b0;
      regWrData <= '0;
    end else begin
      skipReq <= stb.fire & skipNow;
      if (stb.decZero) regWrData <= decVal;
    end
  end

endmodule

// File: rtl/skip_eval.sv
module skip_eval
  import skip_eval_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testValid,
  input  logic [3:0]        testSel,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] memIn,
  input  logic [DATA_W-1:0] immIn,
  input  logic [DATA_W-1:0] bPtrIn,
  input  logic              carryIn,
  input  logic [IDX_W-1:0]  bitIdx,
  output logic              skipValid,
  output logic              skipReq,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData
);

  strobes_t stb;

  skip_eval_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .testValid(testValid),
    .testSel  (testSel),
    .stb      (stb),
    .skipValid(skipValid),
    .regWrEn  (regWrEn)
  );

  skip_eval_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .accIn    (accIn),
    .memIn    (memIn),
    .immIn    (immIn),
    .bPtrIn   (bPtrIn),
    .carryIn  (carryIn),
    .bitIdx   (bitIdx),
    .skipReq  (skipReq),
    .regWrData(regWrData)
  );

endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              testValid,
  input logic [3:0]        testSel,
  input logic [DATA_W-1:0] memIn,
  input logic              carryIn,
  input logic              skipValid,
  input logic              skipReq,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  assert_skip_needs_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    skipReq |-> skipValid);

  assert_wr_needs_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> skipValid);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !testValid |=> (!skipValid && !skipReq && !regWrEn));

  assert_dec_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    (testValid && testSel == 4'd7) |=> (regWrEn && regWrData == ($past(memIn) - ONE)));

  assert_carry_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    (testValid && testSel == 4'd9) |=> (skipValid && skipReq == !$past(carryIn)));

  assert_carry_clr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (testValid && testSel == 4'd10) |=> (skipValid && skipReq == $past(carryIn)));

endmodule

bind skip_eval skip_eval_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .testValid(testValid),
  .testSel  (testSel),
  .memIn    (memIn),
  .carryIn  (carryIn),
  .skipValid(skipValid),
  .skipReq  (skipReq),
  .regWrEn  (regWrEn),
  .regWrData(regWrData)
);

// File: tb/skip_eval_test.sv
module skip_eval_test;

  localparam int DW = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       testValid = 1'b0;
  logic [3:0] testSel = '0;
  logic [7:0] accIn = '0, memIn = '0, immIn = '0, bPtrIn = '0;
  logic       carryIn = 1'b0;
  logic [2:0] bitIdx = '0;
  logic       skipValid, skipReq, regWrEn;
  logic [7:0] regWrData;

  int compared = 0;
  int mismatched = 0;

  // expected outputs for the next cycle
  bit         expV = 0, expS = 0, expW = 0;
  logic [7:0] expD = '0;
  string      expTag = "R1";

  always #4 clk = ~clk;

  skip_eval uut (
    .clk(clk), .rstN(rstN), .testValid(testValid), .testSel(testSel),
    .accIn(accIn), .memIn(memIn), .immIn(immIn), .bPtrIn(bPtrIn),
    .carryIn(carryIn), .bitIdx(bitIdx), .skipValid(skipValid),
    .skipReq(skipReq), .regWrEn(regWrEn), .regWrData(regWrData)
  );

  function automatic string tagOf(input bit v, input int code);
    if (!v) return "R12";
    case (code)
      1: return "R2";  2: return "R3";  3: return "R4";  4: return "R5";
      5: return "R6";  6: return "R7";  7: return "R8";  8: return "R9";
      9: return "R10"; 10: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic compareNow();
    compared++;
    if (skipValid !== expV || skipReq !== expS || regWrEn !== expW ||
        (expW && regWrData !== expD)) begin
      mismatched++;
      $display("FAIL %s: got v=%0b s=%0b w=%0b d=%02h, expected v=%0b s=%0b w=%0b d=%02h",
               expTag, skipValid, skipReq, regWrEn, regWrData, expV, expS, expW, expD);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge, after checking the last one.
  task automatic step(input bit v, input int code, input logic [7:0] a,
                      input logic [7:0] m, input logic [7:0] im,
                      input logic [7:0] b, input bit c, input int idx);
    int mv, res;
    @(negedge clk);
    compareNow();
    testValid = v; testSel = 4'(code); accIn = a; memIn = m; immIn = im;
    bPtrIn = b; carryIn = c; bitIdx = 3'(idx);
    mv = int'(m);
    expV = 0; expS = 0; expW = 0;
    expTag = tagOf(v, code);
    if (v && code >= 1 && code <= 10) begin
      expV = 1;
      case (code)
        1: expS = (a != m);
        2: expS = (m != im);
        3: expS = (a == m);
        4: expS = !(int'(a) > mv);
        5: expS = ((int'(b) % 16) == (int'(im) % 16));
        6: expS = ((a & im) == 0);
        7: begin
             res = (mv + 255) % 256;
             expW = 1; expD = 8'(res); expS = (res == 0);
           end
        8: expS = (((mv >> idx) % 2) == 0);
        9: expS = !c;
        default: expS = c;
      endcase
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      expTag = "R1";
      compareNow();
    end
    rstN = 1'b1;
    expV = 0; expS = 0; expW = 0; expTag = "R1";

    // Directed corner cases
    step(1, 7, 0, 8'h00, 0, 0, 0, 0);        // R8 wrap 0 -> FF, no skip
    step(1, 7, 0, 8'h01, 0, 0, 0, 0);        // R8 1 -> 0, skip
    step(1, 7, 0, 8'h80, 0, 0, 0, 0);        // R8
    step(1, 4, 8'h55, 8'h55, 0, 0, 0, 0);    // R5 equal -> skip
    step(1, 4, 8'h80, 8'h7F, 0, 0, 0, 0);    // R5 unsigned greater -> no skip
    step(1, 5, 0, 0, 8'hA3, 8'h53, 0, 0);    // R6 low nibbles equal -> skip
    step(1, 5, 0, 0, 8'h03, 8'h04, 0, 0);    // R6 differ -> no skip
    step(1, 6, 8'hF0, 0, 8'h0F, 0, 0, 0);    // R7 zero -> skip
    step(1, 9, 0, 0, 0, 0, 1, 0);            // R10
    step(1, 10, 0, 0, 0, 0, 1, 0);           // R10
    step(0, 7, 0, 8'h01, 0, 0, 0, 0);        // R12 no strobe
    step(1, 0, 0, 0, 0, 0, 0, 0);            // R12 code 0
    for (int i = 0; i < 8; i++) step(1, 8, 0, 8'(1 << i), 0, 0, 0, i);      // R9 set
    for (int i = 0; i < 8; i++) step(1, 8, 0, ~8'(1 << i), 0, 0, 0, i);     // R9 clear
    step(1, 2, 0, 8'h3C, 8'h3C, 0, 0, 0);    // R3 equal
    step(1, 1, 8'h3C, 8'h3C, 0, 0, 0, 0);    // R2 equal
    step(1, 3, 8'h3C, 8'h3C, 0, 0, 0, 0);    // R4 equal -> skip

    // Random sweep over every code, with back-to-back and gapped strobes (R11)
    for (int code = 0; code < 16; code++) begin
      for (int n = 0; n < 200; n++) begin
        logic [7:0] a, m;
        a = 8'($urandom);
        m = ($urandom % 4 == 0) ? a : 8'($urandom);
        if (code == 7 && n % 16 == 0) m = 8'(n % 32 == 0 ? 0 : 1);
        step(($urandom % 5) != 0, code, a, m, 8'($urandom), 8'($urandom),
             1'($urandom), int'($urandom % 8));
      end
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compareNow();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule